// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, frame by frame, whether an incoming Ethernet frame should be kept, judging only by its 48-bit destination address. The six address bytes arrive one per clock with a valid strobe, the first of them marked by a start-of-frame flag. Gaps with the strobe low may appear between bytes. While the bytes stream in, the block builds the address and runs a CRC-32 over it. When the sixth byte arrives it compares the address against the configuration and produces a one-cycle result: accept or reject, with a code that names the rule that decided.

The configuration arrives as plain input ports, held steady by whoever owns the registers. It consists of a station address split into a 16-bit high word and a 32-bit low word, five independent enables, and a 128-bit group hash table. The enables are: accept everything, accept every group address, accept the station address, accept broadcast, and accept group addresses found in the hash table.

Top module: `dest_addr_filter`

## Requirements
- R1: While reset is asserted and after it is released, `resultValid` and `accept` are 0 and `reason` is 0 until a sixth address byte has been taken.
- R2: `resultValid` is high for exactly one cycle, the cycle after the sixth taken byte. Cycles with `byteValid` low are skipped and do not count as bytes.
- R3: With `enPromisc` set, every frame is accepted with reason 1.
- R4: The all-ones address is accepted with reason 2 when `enBroadcast` is set. When `enBroadcast` and `enPromisc` are both clear, it is rejected whatever the other enables.
- R5: The station address is byte 0 = `stationHi[15:8]`, byte 1 = `stationHi[7:0]`, byte 2 = `stationLo[31:24]` through byte 5 = `stationLo[7:0]`, with byte 0 arriving first. With `enStation` set, an exact match is accepted with reason 3, and an address differing in any bit is not accepted by this rule.
- R6: A group address is one whose first byte has bit 0 set. With `enAllGroup` set, any non-broadcast group address is accepted with reason 4.
- R7: The hash index is bits 31:25 of the complemented CRC-32 (reflected polynomial 0xEDB88320, initial value all ones) over the six bytes in arrival order, least significant bit of each byte first. With `enHashed` set, a non-broadcast group address whose `hashTable` bit at that index is 1 is accepted with reason 5. An individual (non-group) address is never accepted by hash.
- R8: With `hashTable` all zero, no frame is accepted by the hash rule.
- R9: When several rules apply, the winner is, in falling priority: promiscuous, broadcast, station, all-group, hash.
- R10: `sof` together with `byteValid` starts a new address and abandons any partial one. Valid bytes after the sixth are ignored until the next `sof`.
- R11: When no rule applies, the result is `accept` = 0 with reason 0. `accept` is 1 exactly when a result is valid and its reason is not 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Marks the first destination byte (qualified by byteValid) |
| byteValid | input | 1 | byteIn carries an address byte this cycle |
| byteIn | input | 8 | Destination address byte |
| stationHi | input | 16 | Station address bytes 0 and 1 |
| stationLo | input | 32 | Station address bytes 2 to 5 |
| enPromisc | input | 1 | Accept every frame |
| enAllGroup | input | 1 | Accept every group address |
| enStation | input | 1 | Accept the station address |
| enBroadcast | input | 1 | Accept the broadcast address |
| enHashed | input | 1 | Accept group addresses hitting the hash table |
| hashTable | input | 128 | Group hash table, bit i selected by hash index i |
| resultValid | output | 1 | Decision valid this cycle |
| accept | output | 1 | Frame accepted |
| reason | output | 3 | 0 reject, 1 promiscuous, 2 broadcast, 3 station, 4 all-group, 5 hash |

## Verification
The in-RTL assertions watch, on every cycle, that a result pulse never lasts two cycles, that the byte counter stays in range and restarts on a start marker, that promiscuous mode always wins, that a broadcast with its enable and promiscuous mode off is refused, and that accept agrees with the reason code. Only the bench's scenarios show that the station byte order, the CRC-derived hash index, the priority among overlapping rules, gaps between bytes, aborted partial addresses and trailing bytes after the sixth behave as specified, since these depend on particular address values and sequences.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = ADDR_BYTES * 8;
  localparam int PREFIX_W   = ADDR_W - 8;
  localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  typedef enum logic [2:0] {
    RSN_REJECT   = 3'd0,
    RSN_PROMISC  = 3'd1,
    RSN_BCAST    = 3'd2,
    RSN_STATION  = 3'd3,
    RSN_ALLGROUP = 3'd4,
    RSN_HASHED   = 3'd5
  } reason_e;

  typedef struct packed {
    logic startFrame;
    logic takeByte;
    logic lastByte;
  } ctrl_strobe_t;

  function automatic logic [31:0] crcByte(input logic [31:0] crcIn, input logic [7:0] data);
    logic [31:0] c;
    c = crcIn;
    for (int k = 0; k < 8; k++) begin
      if (c[0] ^ data[k]) c = (c >> 1) ^ CRC_POLY;
      else                c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/addr_filt_ctrl.sv
module addr_filt_ctrl
  import addr_filt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sof,
  input  logic         byteValid,
  output ctrl_strobe_t strb
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] byteCnt;
  logic             busy;

  always_comb begin
    strb.startFrame = byteValid && sof;
    strb.takeByte   = byteValid && (sof || busy);
    strb.lastByte   = byteValid && !sof && busy && (byteCnt == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt <= '0;
      busy    <= 1'b0;
    end else if (strb.startFrame) begin
      byteCnt <= CNT_W'(1);
      busy    <= 1'b1;
    end else if (strb.takeByte) begin
      if (byteCnt == LAST_IDX) begin
        byteCnt <= '0;
        busy    <= 1'b0;
      end else begin
        byteCnt <= byteCnt + CNT_W'(1);
      end
    end
  end

  assert_cnt_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= LAST_IDX);

  assert_sof_restart_R10: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && sof) |=> (busy && byteCnt == CNT_W'(1)));

  assert_idle_after_last_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.lastByte |=> !busy);
endmodule

// File: rtl/addr_filt_dpath.sv
module addr_filt_dpath
  import addr_filt_pkg::*;
#(
  parameter int HASH_IDX_W = 7,
  localparam int TABLE_BITS = 1 << HASH_IDX_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_strobe_t          strb,
  input  logic [7:0]            byteIn,
  input  logic [15:0]           stationHi,
  input  logic [31:0]           stationLo,
  input  logic                  enPromisc,
  input  logic                  enAllGroup,
  input  logic                  enStation,
  input  logic                  enBroadcast,
  input  logic                  enHashed,
  input  logic [TABLE_BITS-1:0] hashTable,
  output logic                  resultValid,
  output logic                  accept,
  output logic [2:0]            reason
);
  logic [PREFIX_W-1:0]   addrHead;
  logic [31:0]           crcAcc;
  logic [31:0]           crcNext;
  logic [31:0]           crcFinal;
  logic [ADDR_W-1:0]     fullAddr;
  logic [ADDR_W-1:0]     stationAddr;
  logic [HASH_IDX_W-1:0] hashIdx;
  logic                  isGroup;
  logic                  isBcast;
  logic                  hashHit;
  reason_e               verdict;

  always_comb begin
    crcNext     = crcByte(strb.startFrame ? 32'hFFFF_FFFF : crcAcc, byteIn);
    crcFinal    = ~crcNext;
    hashIdx     = crcFinal[31 -: HASH_IDX_W];
    fullAddr    = {addrHead, byteIn};
    stationAddr = {stationHi, stationLo};
    isGroup     = fullAddr[ADDR_W-8];
    isBcast     = &fullAddr;
    hashHit     = hashTable[hashIdx];

    if (enPromisc)                             verdict = RSN_PROMISC;
    else if (isBcast)                          verdict = enBroadcast ? RSN_BCAST : RSN_REJECT;
    else if (enStation && fullAddr == stationAddr) verdict = RSN_STATION;
    else if (isGroup && enAllGroup)            verdict = RSN_ALLGROUP;
    else if (isGroup && enHashed && hashHit)   verdict = RSN_HASHED;
    else                                       verdict = RSN_REJECT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrHead <= '0;
      crcAcc   <= '1;
    end else if (strb.startFrame) begin
      addrHead <= {{(PREFIX_W-8){1'b0}}, byteIn};
      crcAcc   <= crcNext;
    end else if (strb.takeByte) begin
      addrHead <= {addrHead[PREFIX_W-9:0], byteIn};
      crcAcc   <= crcNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      accept      <= 1'b0;
      reason      <= RSN_REJECT;
    end else begin
      resultValid <= strb.lastByte;
      accept      <= strb.lastByte && (verdict != RSN_REJECT);
      reason      <= strb.lastByte ? verdict : RSN_REJECT;
    end
  end

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  assert_promisc_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lastByte && enPromisc) |=> (accept && reason == RSN_PROMISC));

  assert_bcast_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lastByte && isBcast && !enBroadcast && !enPromisc) |=> !accept);

  assert_accept_matches_code_R11: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (accept == (reason != RSN_REJECT)));

  assert_quiet_without_result_R1: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> (!accept && reason == RSN_REJECT));
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import addr_filt_pkg::*;
#(
  parameter int HASH_IDX_W = 7,
  localparam int TABLE_BITS = 1 << HASH_IDX_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sof,
  input  logic                  byteValid,
  input  logic [7:0]            byteIn,
  input  logic [15:0]           stationHi,
  input  logic [31:0]           stationLo,
  input  logic                  enPromisc,
  input  logic                  enAllGroup,
  input  logic                  enStation,
  input  logic                  enBroadcast,
  input  logic                  enHashed,
  input  logic [TABLE_BITS-1:0] hashTable,
  output logic                  resultValid,
  output logic                  accept,
  output logic [2:0]            reason
);
  ctrl_strobe_t strb;

  addr_filt_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .sof      (sof),
    .byteValid(byteValid),
    .strb     (strb)
  );

  addr_filt_dpath #(.HASH_IDX_W(HASH_IDX_W)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .byteIn     (byteIn),
    .stationHi  (stationHi),
    .stationLo  (stationLo),
    .enPromisc  (enPromisc),
    .enAllGroup (enAllGroup),
    .enStation  (enStation),
    .enBroadcast(enBroadcast),
    .enHashed   (enHashed),
    .hashTable  (hashTable),
    .resultValid(resultValid),
    .accept     (accept),
    .reason     (reason)
  );
endmodule

// File: tb/sim_dest_addr_filter.sv
`timescale 1ns/1ps
module sim_dest_addr_filter;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         sof = 1'b0;
  logic         byteValid = 1'b0;
  logic [7:0]   byteIn = 8'h00;
  logic [15:0]  stationHi = 16'h021A;
  logic [31:0]  stationLo = 32'h2B3C4D5E;
  logic         enPromisc = 1'b0, enAllGroup = 1'b0, enStation = 1'b0, enBroadcast = 1'b0, enHashed = 1'b0;
  logic [127:0] hashTable = '0;
  logic         resultValid, accept;
  logic [2:0]   reason;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dest_addr_filter u0 (
    .clk(clk), .rstN(rstN), .sof(sof), .byteValid(byteValid), .byteIn(byteIn),
    .stationHi(stationHi), .stationLo(stationLo),
    .enPromisc(enPromisc), .enAllGroup(enAllGroup), .enStation(enStation),
    .enBroadcast(enBroadcast), .enHashed(enHashed), .hashTable(hashTable),
    .resultValid(resultValid), .accept(accept), .reason(reason)
  );

  localparam logic [47:0] STATION = 48'h021A_2B3C_4D5E;
  localparam logic [47:0] OTHERU  = 48'h0011_2233_4455;
  localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC1     = 48'h0100_5E00_0001;
  localparam logic [47:0] NEARST  = 48'h021A_2B3C_4D5F;

  // {address, enables {promisc, allGroup, station, broadcast, hashed}, accept, reason}
  localparam int NV = 13;
  localparam logic [56:0] VEC [NV] = '{
    {OTHERU,  5'b10000, 1'b1, 3'd1},  // R3
    {OTHERU,  5'b01111, 1'b0, 3'd0},  // R11
    {BCAST,   5'b00010, 1'b1, 3'd2},  // R4
    {BCAST,   5'b01101, 1'b0, 3'd0},  // R4
    {STATION, 5'b00100, 1'b1, 3'd3},  // R5
    {NEARST,  5'b00100, 1'b0, 3'd0},  // R5
    {STATION, 5'b01011, 1'b0, 3'd0},  // R5
    {MC1,     5'b01000, 1'b1, 3'd4},  // R6
    {MC1,     5'b00001, 1'b1, 3'd5},  // R7
    {MC1,     5'b00110, 1'b0, 3'd0},  // R6
    {STATION, 5'b10100, 1'b1, 3'd1},  // R9
    {BCAST,   5'b00111, 1'b1, 3'd2},  // R9
    {MC1,     5'b01001, 1'b1, 3'd4}   // R9
  };

  function automatic string vecTag(input int i);
    case (i)
      0: return "R3";
      1: return "R11";
      2, 3: return "R4";
      4, 5, 6: return "R5";
      7, 9: return "R6";
      8: return "R7";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [6:0] hashIndexOf(input logic [47:0] d);
    logic [31:0] c;
    logic [7:0]  b;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      b = d[47 - 8*i -: 8];
      for (int k = 0; k < 8; k++) begin
        if (c[0] ^ b[k]) c = (c >> 1) ^ 32'hEDB88320;
        else             c = c >> 1;
      end
    end
    c = ~c;
    return c[31:25];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic setEnables(input logic [4:0] e);
    {enPromisc, enAllGroup, enStation, enBroadcast, enHashed} = e;
  endtask

  // Drives six bytes; gap idle cycles are inserted before byte 3.
  // Returns at the negedge where the result should be visible.
  task automatic sendAddr(input logic [47:0] d, input int gap);
    for (int i = 0; i < 6; i++) begin
      if (gap > 0 && i == 3) begin
        @(negedge clk); byteValid = 1'b0; sof = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
      @(negedge clk);
      sof = (i == 0);
      byteValid = 1'b1;
      byteIn = d[47 - 8*i -: 8];
    end
    @(negedge clk);
    sof = 1'b0; byteValid = 1'b0;
  endtask

  task automatic expectResult(input string tag, input logic expAcc, input logic [2:0] expRsn);
    check(tag, {31'd0, resultValid}, 32'd1);
    check(tag, {31'd0, accept}, {31'd0, expAcc});
    check(tag, {29'd0, reason}, {29'd0, expRsn});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [6:0] mcIdx;
    mcIdx = hashIndexOf(MC1);

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", {29'd0, resultValid, accept, 1'b0}, 32'd0);
    check("R1", {29'd0, reason}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", {30'd0, resultValid, accept}, 32'd0);

    hashTable = '0;
    hashTable[mcIdx] = 1'b1;

    for (int i = 0; i < NV; i++) begin
      setEnables(VEC[i][8:4]);
      sendAddr(VEC[i][56:9], 0);
      expectResult(vecTag(i), VEC[i][3], VEC[i][2:0]);
      @(negedge clk);
    end

    // R2: gap inside the address, pulse lasts one cycle
    setEnables(5'b00100);
    sendAddr(STATION, 4);
    expectResult("R2", 1'b1, 3'd3);
    @(negedge clk);
    check("R2", {31'd0, resultValid}, 32'd0);

    // R10: partial station address aborted by a new start marker
    setEnables(5'b01000);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); sof = (i == 0); byteValid = 1'b1; byteIn = STATION[47 - 8*i -: 8];
    end
    sendAddr(MC1, 0);
    expectResult("R10", 1'b1, 3'd4);
    @(negedge clk);

    // R10: bytes after the sixth are ignored
    setEnables(5'b10000);
    sendAddr(OTHERU, 0);
    expectResult("R10", 1'b1, 3'd1);
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk); byteValid = 1'b1; sof = 1'b0; byteIn = 8'hA5;
        if (i > 0 && resultValid) seen++;
      end
      @(negedge clk); byteValid = 1'b0;
      if (resultValid) seen++;
      @(negedge clk);
      if (resultValid) seen++;
      check("R10", seen, 0);
    end

    // R8: empty table gives no hash acceptance
    hashTable = '0;
    setEnables(5'b00001);
    sendAddr(MC1, 0);
    expectResult("R8", 1'b0, 3'd0);
    @(negedge clk);

    // R7: full table never admits an individual address, still admits a group one
    hashTable = '1;
    sendAddr(OTHERU, 0);
    expectResult("R7", 1'b0, 3'd0);
    @(negedge clk);
    sendAddr(MC1, 0);
    expectResult("R7", 1'b1, 3'd5);
    @(negedge clk);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule